// File: doc/BRIEF.md
# Beat-Serial Rounding Dual Multiply-Accumulate Unit

This unit folds the four 32-bit lanes of two 128-bit vector operands into one 64-bit running sum, one lane per clock. For each lane it takes a full-width 32x32 product, scales it down by 256 with round-half-up, and adds it to the sum. A per-lane predicate skips lanes. Mode inputs select signed or unsigned arithmetic, a crossed pairing of neighbouring lanes, and negation of the odd-lane terms.

The sum is kept at 64 bits after every beat. Nothing above bit 63 carries from one lane to the next. A caller pulses `start_i` with operands, a starting sum and modes. It then waits for the single-cycle `done_o` pulse and reads `result_o`, which holds its value until the next accepted start.

Top module: `rdmac_unit`

## Requirements
- R1: A `start_i` sampled high on a clock edge while `busy_o` is low captures all inputs, loads the starting sum into `result_o`, and raises `busy_o` from that edge on.
- R2: The lanes are processed in order 0, 1, 2, 3, one on each of the four edges after the start edge. `done_o` is high for exactly one cycle, beginning at the fourth of those edges, and `busy_o` is low by then.
- R3: Each lane product is the full 64-bit result of a 32x32 multiply. It is two's-complement when `is_signed_i`=1 and unsigned when `is_signed_i`=0, so 0x80000000 times 0x80000000 gives 2^62 in both modes.
- R4: Bit 4*e of `pred_i` enables lane e. The other three bits of each 4-bit group are ignored. On a disabled lane's beat the sum does not change.
- R5: With `exchange_i`=1, lane e multiplies N lane (e XOR 1) by M lane e. With `exchange_i`=0 it multiplies N lane e by M lane e. Lane k sits in bits [32k+31:32k].
- R6: With `subtract_i`=1 and signed mode, the products of lanes 1 and 3 are negated, in 64-bit two's complement, before rounding. Even lanes are always added. In unsigned mode `subtract_i` has no effect.
- R7: A product p is rounded as (p shifted right by 8) + bit 7 of p. The shift is arithmetic in signed mode and logical in unsigned mode.
- R8: Each rounded term is added to the 64-bit sum modulo 2^64 on its beat.
- R9: `result_o` stays stable while idle with no start. A `start_i` that arrives while `busy_o` is high is ignored and does not alter the result.
- R10: While `rst_ni` is low, `busy_o` and `done_o` are 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| vec_n_i | input | 128 | First vector operand, four 32-bit lanes |
| vec_m_i | input | 128 | Second vector operand, four 32-bit lanes |
| acc_i | input | 64 | Starting sum |
| pred_i | input | 16 | Lane predicate, bit 4*e enables lane e |
| is_signed_i | input | 1 | 1 = signed products, 0 = unsigned |
| exchange_i | input | 1 | Cross N lanes within each even/odd pair |
| subtract_i | input | 1 | Negate odd-lane products (signed mode only) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Running, then final, 64-bit sum |

## Verification
A start driven before edge k puts `busy_o` high from edge k. The four lane beats land on edges k+1 to k+4, and `done_o` with the final sum appears after edge k+4. The bench therefore checks `busy_o` at the falling edge following k. It records the edge count at issue, and its monitor compares the sum at the falling edge where `done_o` is seen, requiring exactly five rising edges since issue. Stability checks, covering idle hold and ignored starts, sample `result_o` on several falling edges after `done_o`, while no new start is pending.

// File: rtl/rdmac_pkg.sv
package rdmac_pkg;
  localparam int unsigned LANE_W_DEF    = 32;
  localparam int unsigned NUM_LANES_DEF = 4;
  localparam int unsigned PRED_GRP_DEF  = 4;
  localparam int unsigned RND_SHIFT_DEF = 8;

  typedef struct packed {
    logic is_signed;
    logic exchange;
    logic subtract;
  } rdmac_mode_t;
endpackage

// File: rtl/rdmac_beat_ctrl.sv
module rdmac_beat_ctrl #(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] beat_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LANES - 1);

  logic             busy_q, done_q;
  logic [IDX_W-1:0] beat_q;

  assign accept_o = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      beat_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        beat_q <= '0;
      end else if (busy_q) begin
        if (beat_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          beat_q <= '0;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;
  assign done_o = done_q;
endmodule

// File: rtl/rdmac_lane_pick.sv
module rdmac_lane_pick #(
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned VEC_W    = LANE_W * NUM_LANES,
  localparam int unsigned IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic [VEC_W-1:0]  vec_n_i,
  input  logic [VEC_W-1:0]  vec_m_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              exchange_i,
  output logic [LANE_W-1:0] op_n_o,
  output logic [LANE_W-1:0] op_m_o
);
  logic [LANE_W-1:0] n_lane [NUM_LANES];
  logic [LANE_W-1:0] m_lane [NUM_LANES];
  logic [IDX_W-1:0]  n_idx;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_split
    assign n_lane[g] = vec_n_i[g*LANE_W +: LANE_W];
    assign m_lane[g] = vec_m_i[g*LANE_W +: LANE_W];
  end

  // crossed pairing: partner of lane e is e^1
  assign n_idx  = exchange_i ? (idx_i ^ IDX_W'(1)) : idx_i;
  assign op_n_o = n_lane[n_idx];
  assign op_m_o = m_lane[idx_i];
endmodule

// File: rtl/rdmac_lane_mac.sv
module rdmac_lane_mac #(
  parameter int unsigned LANE_W    = 32,
  parameter int unsigned RND_SHIFT = 8,
  localparam int unsigned ACC_W    = 2 * LANE_W
) (
  input  logic [LANE_W-1:0] op_a_i,
  input  logic [LANE_W-1:0] op_b_i,
  input  logic              is_signed_i,
  input  logic              negate_i,
  input  logic              enable_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [ACC_W-1:0]  acc_o
);
  logic [ACC_W-1:0] ext_a, ext_b, prod, term, shifted, rounded;
  logic             fill;

  assign ext_a = is_signed_i ? {{LANE_W{op_a_i[LANE_W-1]}}, op_a_i} : {{LANE_W{1'b0}}, op_a_i};
  assign ext_b = is_signed_i ? {{LANE_W{op_b_i[LANE_W-1]}}, op_b_i} : {{LANE_W{1'b0}}, op_b_i};

  // low ACC_W bits of extended operands give the exact product in either mode
  assign prod    = ext_a * ext_b;
  assign term    = negate_i ? (~prod + 1'b1) : prod;
  assign fill    = is_signed_i & term[ACC_W-1];
  assign shifted = {{RND_SHIFT{fill}}, term[ACC_W-1:RND_SHIFT]};
  assign rounded = shifted + {{(ACC_W-1){1'b0}}, term[RND_SHIFT-1]};
  assign acc_o   = enable_i ? (acc_i + rounded) : acc_i;
endmodule

// File: rtl/rdmac_unit.sv
module rdmac_unit
  import rdmac_pkg::*;
#(
  parameter int unsigned LANE_W    = LANE_W_DEF,
  parameter int unsigned NUM_LANES = NUM_LANES_DEF,
  parameter int unsigned PRED_GRP  = PRED_GRP_DEF,
  parameter int unsigned RND_SHIFT = RND_SHIFT_DEF,
  localparam int unsigned VEC_W    = LANE_W * NUM_LANES,
  localparam int unsigned ACC_W    = 2 * LANE_W,
  localparam int unsigned PRED_W   = PRED_GRP * NUM_LANES,
  localparam int unsigned IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VEC_W-1:0]  vec_n_i,
  input  logic [VEC_W-1:0]  vec_m_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic              is_signed_i,
  input  logic              exchange_i,
  input  logic              subtract_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ACC_W-1:0]  result_o
);
  logic                 accept;
  logic [IDX_W-1:0]     beat;
  logic [VEC_W-1:0]     vec_n_q, vec_m_q;
  logic [NUM_LANES-1:0] lane_en_q, lane_en_in;
  rdmac_mode_t          mode_q;
  logic [ACC_W-1:0]     acc_q, acc_next;
  logic [LANE_W-1:0]    op_n, op_m;
  logic                 lane_en, negate;
  logic                 unused_pred;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pred
    assign lane_en_in[g] = pred_i[g*PRED_GRP];
  end
  assign unused_pred = ^pred_i;

  rdmac_beat_ctrl #(.NUM_LANES(NUM_LANES)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .beat_o   (beat),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_n_q   <= '0;
      vec_m_q   <= '0;
      lane_en_q <= '0;
      mode_q    <= '0;
      acc_q     <= '0;
    end else if (accept) begin
      vec_n_q   <= vec_n_i;
      vec_m_q   <= vec_m_i;
      lane_en_q <= lane_en_in;
      mode_q    <= '{is_signed: is_signed_i, exchange: exchange_i,
                     subtract: subtract_i & is_signed_i};  // unsigned subtract -> add
      acc_q     <= acc_i;
    end else if (busy_o) begin
      acc_q     <= acc_next;
    end
  end

  rdmac_lane_pick #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_pick (
    .vec_n_i    (vec_n_q),
    .vec_m_i    (vec_m_q),
    .idx_i      (beat),
    .exchange_i (mode_q.exchange),
    .op_n_o     (op_n),
    .op_m_o     (op_m)
  );

  assign lane_en = lane_en_q[beat];
  assign negate  = mode_q.subtract & beat[0];

  rdmac_lane_mac #(.LANE_W(LANE_W), .RND_SHIFT(RND_SHIFT)) u_mac (
    .op_a_i      (op_n),
    .op_b_i      (op_m),
    .is_signed_i (mode_q.is_signed),
    .negate_i    (negate),
    .enable_i    (lane_en),
    .acc_i       (acc_q),
    .acc_o       (acc_next)
  );

  assign result_o = acc_q;
endmodule

// File: rtl/rdmac_unit_chk.sv
module rdmac_unit_chk #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned ACC_W     = 64,
  localparam int unsigned CNT_W    = $clog2(NUM_LANES + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             lane_en,
  input logic [ACC_W-1:0] result_o
);
  logic [CNT_W-1:0] beats_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  beats_seen <= '0;
    else if (start_i && !busy_o)  beats_seen <= '0;
    else if (busy_o)              beats_seen <= beats_seen + 1'b1;
  end

  assert_accept_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_beat_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> beats_seen == CNT_W'(NUM_LANES));

  assert_masked_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !lane_en |=> $stable(result_o));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(result_o));
endmodule

bind rdmac_unit rdmac_unit_chk #(.NUM_LANES(NUM_LANES), .ACC_W(ACC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .lane_en  (lane_en),
  .result_o (result_o)
);

// File: tb/rdmac_unit_tb_top.sv
module rdmac_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 150000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] vec_n_i = '0, vec_m_i = '0;
  logic [63:0]  acc_i = '0;
  logic [15:0]  pred_i = '0;
  logic         is_signed_i = 1'b0, exchange_i = 1'b0, subtract_i = 1'b0;
  logic         busy_o, done_o;
  logic [63:0]  result_o;

  int n_checks = 0, n_fails = 0;
  longint cyc = 0;
  bit summary_done = 1'b0;

  typedef struct {
    logic [63:0] exp;
    longint      issue;
    string       tag;
  } sb_item_t;
  sb_item_t sb_q[$];
  logic [63:0] last_exp;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  rdmac_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .vec_n_i(vec_n_i), .vec_m_i(vec_m_i), .acc_i(acc_i), .pred_i(pred_i),
    .is_signed_i(is_signed_i), .exchange_i(exchange_i), .subtract_i(subtract_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3 R5 R6 R7 R8 R4 model
  function automatic logic [63:0] model(input logic [127:0] n, input logic [127:0] m,
                                        input logic [63:0] a, input logic [15:0] p,
                                        input bit s, input bit x, input bit sub);
    logic [63:0] acc, pr, r;
    logic [31:0] an, bm;
    int ne;
    acc = a;
    for (int e = 0; e < 4; e++) begin
      if (p[4*e]) begin
        ne = x ? (e ^ 1) : e;
        an = n[32*ne +: 32];
        bm = m[32*e +: 32];
        if (s) pr = 64'(longint'($signed(an)) * longint'($signed(bm)));
        else   pr = {32'b0, an} * {32'b0, bm};
        if (s && sub && (e % 2 == 1)) pr = -pr;
        r = s ? 64'($signed(pr) >>> 8) : (pr >> 8);
        r = r + {63'b0, pr[7]};
        acc = acc + r;
      end
    end
    return acc;
  endfunction

  task automatic run_vec(input logic [127:0] n, input logic [127:0] m, input logic [63:0] a,
                         input logic [15:0] p, input bit s, input bit x, input bit sub,
                         input string tag);
    sb_item_t it;
    while (busy_o) @(negedge clk_i);
    it.exp   = model(n, m, a, p, s, x, sub);
    it.issue = cyc;
    it.tag   = tag;
    sb_q.push_back(it);
    last_exp = it.exp;
    vec_n_i = n; vec_m_i = m; acc_i = a; pred_i = p;
    is_signed_i = s; exchange_i = x; subtract_i = sub;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R1 busy after start", {63'b0, busy_o}, 64'd1);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o === 1'b1) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", 64'd1, 64'd0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(result_o === it.exp, it.tag, result_o, it.exp);
        check(cyc - it.issue == 5, "R2 done latency", 64'(cyc - it.issue), 64'd5);
      end
    end
  end

  task automatic finish_up();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d", WATCHDOG, WATCHDOG);
    finish_up();
  end

  function automatic logic [127:0] lanes(input logic [31:0] l3, input logic [31:0] l2,
                                         input logic [31:0] l1, input logic [31:0] l0);
    return {l3, l2, l1, l0};
  endfunction

  initial begin
    logic [127:0] vn, vm;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(busy_o === 1'b0, "R10 busy in reset", {63'b0, busy_o}, 64'd0);
    check(done_o === 1'b0, "R10 done in reset", {63'b0, done_o}, 64'd0);
    check(result_o === 64'd0, "R10 result in reset", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 extreme products
    vn = lanes(32'h0, 32'h0, 32'h0, 32'h8000_0000);
    run_vec(vn, vn, 64'd0, 16'h0001, 1, 0, 0, "R3 signed min*min");
    run_vec(vn, vn, 64'd0, 16'h0001, 0, 0, 0, "R3 unsigned 8000_0000^2");
    vn = lanes(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_vec(vn, vn, 64'd0, 16'h1111, 0, 0, 0, "R3 unsigned max*max");
    run_vec(vn, vn, 64'd0, 16'h1111, 1, 0, 0, "R3 signed -1*-1");
    // R7 rounding edges
    run_vec(lanes(0, 0, 0, 32'h80), lanes(0, 0, 0, 1), 64'd0, 16'h0001, 1, 0, 0, "R7 +128 rounds to 1");
    run_vec(lanes(0, 0, 0, 32'hFFFF_FF80), lanes(0, 0, 0, 1), 64'd0, 16'h0001, 1, 0, 0, "R7 -128 rounds to 0");
    run_vec(lanes(0, 0, 0, 32'h7F), lanes(0, 0, 0, 1), 64'd5, 16'h0001, 1, 0, 0, "R7 127 rounds to 0");
    run_vec(lanes(0, 0, 0, 32'hFFFF_FF00), lanes(0, 0, 0, 1), 64'd0, 16'h0001, 0, 0, 0, "R7 logical shift unsigned");
    // R8 wrap
    run_vec(lanes(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF),
            lanes(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF),
            64'hFFFF_FFFF_FFFF_FFF0, 16'h1111, 1, 0, 0, "R8 wrap high");
    // R5 exchange pairing with distinct lanes
    vn = lanes(32'd4000, 32'd3000, 32'd2000, 32'd1000);
    vm = lanes(32'd13, 32'd11, 32'd7, 32'd5);
    run_vec(vn, vm, 64'd0, 16'h1111, 1, 1, 0, "R5 exchange on");
    run_vec(vn, vm, 64'd0, 16'h1111, 1, 0, 0, "R5 exchange off");
    // R6 subtract
    run_vec(vn, vm, 64'd100, 16'h1111, 1, 0, 1, "R6 signed subtract odd");
    run_vec(vn, vm, 64'd100, 16'h1111, 0, 0, 1, "R6 unsigned subtract ignored");
    run_vec(vn, vm, 64'd100, 16'h1111, 1, 1, 1, "R6 subtract with exchange");
    // R4 predicate groups
    run_vec(vn, vm, 64'h1234, 16'hEEEE, 1, 0, 0, "R4 upper group bits ignored");
    run_vec(vn, vm, 64'h1234, 16'h0000, 1, 0, 0, "R4 all disabled");
    run_vec(vn, vm, 64'h1234, 16'h1010, 1, 0, 0, "R4 lanes 1 and 3 only");
    run_vec(vn, vm, 64'h1234, 16'h0101, 1, 0, 1, "R4 lanes 0 and 2 with subtract");

    // R9 ignored start while busy
    run_vec(vn, vm, 64'd77, 16'h1111, 1, 0, 0, "R9 result with ignored start");
    acc_i = 64'hDEAD_BEEF; pred_i = 16'h0000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);
    // R9 hold after done
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check(result_o === last_exp, "R9 hold while idle", result_o, last_exp);
      check(busy_o === 1'b0, "R9 no restart from ignored start", {63'b0, busy_o}, 64'd0);
    end

    // random, all mode combinations
    for (int i = 0; i < 400; i++) begin
      logic [127:0] rn, rm;
      logic [63:0]  ra;
      logic [15:0]  rp;
      rn = {$urandom, $urandom, $urandom, $urandom};
      rm = {$urandom, $urandom, $urandom, $urandom};
      if (i % 16 == 0) rn = {4{32'h8000_0000}};
      if (i % 16 == 1) rm = {4{32'h8000_0000}};
      ra = {$urandom, $urandom};
      rp = 16'($urandom);
      run_vec(rn, rm, ra, rp, i[0], i[1], i[2], "R8 random sum");
    end

    while (sb_q.size() != 0 || busy_o) @(negedge clk_i);
    @(negedge clk_i);
    check(done_o === 1'b0, "R2 done single pulse", {63'b0, done_o}, 64'd0);
    finish_up();
  end
endmodule